// File: doc/BRIEF.md
# Fractional Tributary Rate Enable Generator

This block runs on the high-speed line clock of a third-order multiplexer (DS3 or E3 rate) and produces a single-cycle enable pulse. Averaged over time, the pulses arrive at the second-order tributary rate (DS2 or E2) that corresponds to a fixed stuffing ratio. Downstream logic uses the enable to advance second-order framing and payload logic in the line clock domain. No second clock and no separate tributary clock pin is needed.

The rate is a ratio of integers. For each line mode there is a payload-bit count per frame (the numerator N) and a total frame length (the modulus M). A programmable fractional stuff rate is subtracted from N. A phase accumulator adds `N*256 - stuff_rate` on every line clock edge. When the sum reaches `M*256`, the accumulator subtracts `M*256` and the enable fires. In C-bit parity mode the stuffing is fixed at 100 %, so the programmed stuff rate has no effect. The block carries no data stream, so it has no valid/ready handshake. All pins are plain control and status pins.

Top module: `trib_rate_gen`

## Requirements
- R1: While `rst_n` is low, `rate_en` is low and the accumulator is zero. After reset is released, the pulse count starts again from that zero phase.
- R2: `mode_sel` = 0 selects DS3 framing. Over the first T edges after reset with a constant `stuff_rate` = s, the number of cycles with `rate_en` high is floor(T*(672*256 - s)/(4760*256)). Over one full 4760-edge frame this gives 672 pulses for s = 0 and 671 for any s > 0.
- R3: `mode_sel` = 2 selects E3. Over the first T edges the count is floor(T*(378*256 - s)/(1536*256)). Over one full 1536-edge frame this gives 378 pulses for s = 0 and 377 for s > 0.
- R4: `mode_sel` = 1 selects DS3 C-bit parity. The step is fixed at 671*256 whatever `stuff_rate` holds, so the count is floor(T*671/4760).
- R5: `stuff_rate` is an unsigned fraction in units of 1/256. A larger value gives an equal or lower pulse count. `mode_sel` = 3 behaves exactly like E3.
- R6: `rate_en` is registered. It is high in the cycle after the edge on which the accumulator sum reached the modulus. For s = 0, the first pulse after reset follows edge 5 in E3 and edge 8 in DS3 framing.
- R7: A change of `mode_sel` or `stuff_rate` applies to the step added on the next edge and does not clear the accumulator. The pulses that follow continue from the residual phase.
- R8: When the accumulator was below the modulus in force at a wrap, the next cycle has no pulse. This is always the case in steady state.
- R9: On a pulse cycle the accumulator value has decreased from the previous cycle. On every other cycle it has not decreased, and it always stays below the largest modulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock (DS3 or E3 rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | 0 DS3 framing, 1 DS3 C-bit parity, 2 E3, 3 E3 |
| stuff_rate | input | FRAC_W (8) | Fractional stuff rate, units of 1/256 |
| rate_en | output | 1 | One-cycle tributary rate enable |

## Verification
The bound checker watches every cycle for the following:
- `rate_en` is quiet in reset.
- No back-to-back pulses occur after an in-range wrap.
- The accumulator falls exactly on pulse cycles, never falls on other cycles, and stays bounded.

The pulse rate itself can only be shown by the bench's scenarios, which count pulses over whole frames and partial windows and compare them with the floor formulas. The same applies to the following:
- that C-bit parity mode ignores the stuff rate;
- the position of the first pulse;
- the carried residual phase across live mode and stuff-rate changes.

// File: rtl/trib_rate_pkg.sv
package trib_rate_pkg;
  typedef enum logic [1:0] {
    MODE_DS3_FRAMED = 2'd0,
    MODE_DS3_CBIT   = 2'd1,
    MODE_E3         = 2'd2,
    MODE_E3_ALT     = 2'd3
  } line_mode_e;
endpackage

// File: rtl/rate_step_sel.sv
// Chooses the per-edge phase step and the wrap modulus for the current mode.
module rate_step_sel #(
  parameter int unsigned FRAC_W  = 8,
  parameter int unsigned DS3_PAY = 672,
  parameter int unsigned DS3_LEN = 4760,
  parameter int unsigned E3_PAY  = 378,
  parameter int unsigned E3_LEN  = 1536,
  parameter int unsigned ACC_W   = 22
) (
  input  logic [1:0]        mode_i,
  input  logic [FRAC_W-1:0] stuff_i,
  output logic [ACC_W-1:0]  step_o,
  output logic [ACC_W-1:0]  modulus_o
);
  import trib_rate_pkg::*;

  localparam int unsigned ONE = 2 ** FRAC_W;
  localparam logic [ACC_W-1:0] DS3_FULL  = ACC_W'(DS3_PAY * ONE);
  localparam logic [ACC_W-1:0] DS3_FIXED = ACC_W'((DS3_PAY - 1) * ONE);
  localparam logic [ACC_W-1:0] E3_FULL   = ACC_W'(E3_PAY * ONE);
  localparam logic [ACC_W-1:0] DS3_MOD   = ACC_W'(DS3_LEN * ONE);
  localparam logic [ACC_W-1:0] E3_MOD    = ACC_W'(E3_LEN * ONE);

  logic [ACC_W-1:0] stuff_ext;
  assign stuff_ext = ACC_W'(stuff_i);

  always_comb begin
    unique case (line_mode_e'(mode_i))
      MODE_DS3_FRAMED: begin
        step_o    = DS3_FULL - stuff_ext;
        modulus_o = DS3_MOD;
      end
      MODE_DS3_CBIT: begin
        // full stuffing: programmed fraction is not used
        step_o    = DS3_FIXED;
        modulus_o = DS3_MOD;
      end
      default: begin
        step_o    = E3_FULL - stuff_ext;
        modulus_o = E3_MOD;
      end
    endcase
  end
endmodule

// File: rtl/phase_wrap_acc.sv
// Modular phase accumulator with a registered wrap pulse.
module phase_wrap_acc #(
  parameter int unsigned ACC_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] step_i,
  input  logic [ACC_W-1:0] modulus_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             wrap_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] sum;
  logic             hit;

  assign sum = acc_q + step_i;
  assign hit = (sum >= modulus_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      wrap_o <= 1'b0;
    end else begin
      acc_q  <= hit ? (sum - modulus_i) : sum;
      wrap_o <= hit;
    end
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/trib_rate_gen.sv
module trib_rate_gen #(
  parameter int unsigned FRAC_W  = 8,
  parameter int unsigned DS3_PAY = 672,
  parameter int unsigned DS3_LEN = 4760,
  parameter int unsigned E3_PAY  = 378,
  parameter int unsigned E3_LEN  = 1536
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_sel,
  input  logic [FRAC_W-1:0] stuff_rate,
  output logic              rate_en
);
  localparam int unsigned LEN_MAX = (DS3_LEN > E3_LEN) ? DS3_LEN : E3_LEN;
  localparam int unsigned MOD_MAX = LEN_MAX * (2 ** FRAC_W);
  localparam int unsigned ACC_W   = $clog2(2 * MOD_MAX);

  logic [ACC_W-1:0] step_w;
  logic [ACC_W-1:0] modulus_w;
  logic [ACC_W-1:0] acc_q;

  rate_step_sel #(
    .FRAC_W(FRAC_W), .DS3_PAY(DS3_PAY), .DS3_LEN(DS3_LEN),
    .E3_PAY(E3_PAY), .E3_LEN(E3_LEN), .ACC_W(ACC_W)
  ) u_sel (
    .mode_i   (mode_sel),
    .stuff_i  (stuff_rate),
    .step_o   (step_w),
    .modulus_o(modulus_w)
  );

  phase_wrap_acc #(.ACC_W(ACC_W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_i   (step_w),
    .modulus_i(modulus_w),
    .acc_o    (acc_q),
    .wrap_o   (rate_en)
  );
endmodule

// File: rtl/trib_rate_chk.sv
module trib_rate_chk #(
  parameter int unsigned ACC_W   = 22,
  parameter int unsigned MOD_MAX = 4760 * 256
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rate_en,
  input logic [ACC_W-1:0] acc_i,
  input logic [ACC_W-1:0] mod_i
);
  // R1: no pulse out of reset
  p_rst_quiet_r1: assert property (@(posedge clk) !rst_n |=> !rate_en)
    else $error("p_rst_quiet_r1");

  // R8: an in-range wrap is never followed by another pulse
  p_no_back_to_back_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_en && ($past(acc_i) < $past(mod_i))) |=> !rate_en)
    else $error("p_no_back_to_back_r8");

  // R9: phase drops exactly on pulse cycles
  p_wrap_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rate_en |-> (acc_i < $past(acc_i)))
    else $error("p_wrap_drop_r9");

  p_climb_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rate_en |-> (acc_i >= $past(acc_i)))
    else $error("p_climb_r9");

  p_bounded_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_i < ACC_W'(MOD_MAX))
    else $error("p_bounded_r9");
endmodule

bind trib_rate_gen trib_rate_chk #(.ACC_W(ACC_W), .MOD_MAX(MOD_MAX)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .rate_en(rate_en),
  .acc_i  (acc_q),
  .mod_i  (modulus_w)
);

// File: tb/tb_trib_rate_gen.sv
module tb_trib_rate_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_sel = 2'd0;
  logic [7:0] stuff_rate = 8'd0;
  logic       rate_en;

  int unsigned n_checks = 0;
  int unsigned n_fail   = 0;
  int unsigned n_pairs  = 0;
  logic        prev_en  = 1'b0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  trib_rate_gen dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .stuff_rate(stuff_rate), .rate_en(rate_en)
  );

  task automatic check_eq(input string tag, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint step_of(input int m, input int s);
    if (m == 0) return 672 * 256 - s;
    if (m == 1) return 671 * 256;
    return 378 * 256 - s;
  endfunction

  function automatic longint mod_of(input int m);
    return (m <= 1) ? 4760 * 256 : 1536 * 256;
  endfunction

  task automatic restart(input int m, input int s);
    @(negedge clk);
    rst_n = 1'b0;
    mode_sel = 2'(m);
    stuff_rate = 8'(s);
    prev_en = 1'b0;
    repeat (2) @(negedge clk);
    check_eq("R1 rate_en low in reset", longint'(rate_en), 0);
    rst_n = 1'b1;
  endtask

  // Apply T edges, counting pulses and noting the first pulse index.
  task automatic run_edges(input int t, output longint cnt, output int first);
    cnt = 0;
    first = 0;
    for (int i = 1; i <= t; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (rate_en) begin
        cnt++;
        if (first == 0) first = i;
        if (prev_en) n_pairs++;
      end
      prev_en = rate_en;
    end
  endtask

  task automatic window(input string tag, input int m, input int s, input int t);
    longint cnt;
    int first;
    restart(m, s);
    run_edges(t, cnt, first);
    check_eq(tag, cnt, (longint'(t) * step_of(m, s)) / mod_of(m));
  endtask

  initial begin
    longint c;
    longint c2;
    longint resid;
    int f;

    // R1/R6: first pulse position from zero phase
    restart(2, 0);
    run_edges(10, c, f);
    check_eq("R6 first E3 pulse edge", f, 5);
    restart(0, 0);
    run_edges(10, c, f);
    check_eq("R6 first DS3 pulse edge", f, 8);

    // R2: full DS3 frames
    window("R2 DS3 frame s=0", 0, 0, 4760);
    window("R2 DS3 frame s=1", 0, 1, 4760);
    window("R2 DS3 frame s=128", 0, 128, 4760);
    window("R2 DS3 frame s=255", 0, 255, 4760);
    window("R2 DS3 partial s=77", 0, 77, 1000);

    // R4: C-bit parity ignores stuff_rate
    window("R4 C-bit frame s=0", 1, 0, 4760);
    window("R4 C-bit frame s=255", 1, 255, 4760);
    restart(1, 200);
    run_edges(2000, c, f);
    check_eq("R4 C-bit partial s=200", c, (2000 * 671) / 4760);

    // R3/R5: E3 sweep over stuff values, plus mode 3 alias
    for (int s = 0; s < 256; s += 17) begin
      window("R3 E3 frame sweep", 2, s, 1536);
      window("R5 mode 3 as E3", 3, s, 700);
    end
    window("R3 E3 partial s=200", 2, 200, 999);

    // R5: monotonic in stuff_rate over a long window
    restart(0, 0);
    run_edges(3000, c, f);
    restart(0, 255);
    run_edges(3000, c2, f);
    check_eq("R5 larger stuff not faster", longint'(c2 <= c), 1);

    // R7: live mode change carries the residual phase
    restart(2, 0);
    run_edges(1000, c, f);
    check_eq("R7 E3 leg", c, (1000 * step_of(2, 0)) / mod_of(2));
    resid = (1000 * step_of(2, 0)) % mod_of(2);
    mode_sel = 2'd0;
    stuff_rate = 8'd100;
    run_edges(3000, c2, f);
    check_eq("R7 DS3 leg after switch", c2,
             (resid + 3000 * step_of(0, 100)) / mod_of(0));

    // R7: live stuff change, same modulus
    restart(0, 10);
    run_edges(1234, c, f);
    stuff_rate = 8'd250;
    run_edges(2345, c2, f);
    check_eq("R7 stuff change total", c + c2,
             (1234 * step_of(0, 10) + 2345 * step_of(0, 250)) / mod_of(0));

    // R8: no back-to-back pulses seen in any run
    check_eq("R8 consecutive pulses", n_pairs, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule